// File: doc/BRIEF.md
# Burst Host Bus Slave Port

This block lets an 8-bit asynchronous host processor reach an internal register and buffer space. The host uses separate active-low read and write strobes, an active-low select and an address-latch pulse. Every host pin is first brought into the system clock through a two-stage synchronizer, and the block then works on the detected edges of those pins. One address phase opens a burst. Each later strobe in the same selection reuses an internal pointer that steps by one at the end of every completed access, so the host can stream bytes into consecutive locations without sending a new address.

On the internal side, writes leave as a valid/ready stream carrying an address and a byte. Reads go out as a valid/ready request carrying an address, and the byte comes back on `rd_data` in the cycle of the handshake. Both streams accept back-pressure. A stalled write stream holds the ready pin to the host low on the next write. A stalled read request holds it low until the byte arrives. The host must wait for ready before it releases a strobe. It must also keep the data byte stable while the write strobe is low and for at least three clocks after that strobe rises.

Top module: `host_bus_burst_if`

## Requirements
- R1: While reset is held, `bus_rdy`, `reg_wr_valid` and `rd_valid` are low.
- R2: With `bus_cs_n` low, a high-to-low transition of `bus_ale` loads the address on `bus_addr` into the pointer. The first access of the burst then targets exactly that address.
- R3: Each completed access (a strobe going low and then back high) advances the pointer by one. The pointer wraps from 0x7FF to 0x000.
- R4: A read in a burst issues a request for the current pointer. The byte returned is then driven on `bus_data` until the read strobe rises.
- R5: The block drives `bus_data` only while both `bus_cs_n` and `bus_rd_n` are low. In every other state the pins are left to other drivers.
- R6: `bus_rdy` rises only after a strobe falling edge has been seen. It falls within a few clocks of that strobe returning high.
- R7: `reg_wr_valid`, once high, stays high with `reg_wr_addr` and `reg_wr_data` unchanged until a cycle in which `reg_wr_ready` is high. While a write is still waiting, `bus_rdy` stays low for a new write strobe.
- R8: `rd_valid`, once high, stays high with `rd_addr` unchanged until `rd_ready` is high. `bus_rdy` stays low for that read until the handshake completes.
- R9: Strobes given while `bus_cs_n` is high cause no write, no read request and no `bus_rdy`.
- R10: `bus_cs_n` rising ends the burst. Strobes after a fresh selection and before a new `bus_ale` falling edge are ignored.
- R11: The byte written is the value on `bus_data` when the write strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 11 | Host address, sampled at the latch-pulse fall |
| bus_cs_n | input | 1 | Host select, active low |
| bus_ale | input | 1 | Address latch pulse, address taken on its fall |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_data | inout | 8 | Host data byte |
| bus_rdy | output | 1 | Access ready to host |
| reg_wr_valid | output | 1 | Write stream valid |
| reg_wr_ready | input | 1 | Write stream ready |
| reg_wr_addr | output | 11 | Write target address |
| reg_wr_data | output | 8 | Write byte |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted, `rd_data` valid |
| rd_addr | output | 11 | Read target address |
| rd_data | input | 8 | Read byte from register space |

## Verification
The bench runs bursts that cross the top of the address space. A pointer that fails to wrap, or that skips or repeats a step, sends writes to the wrong places, and the scoreboard catches the mismatch. It mixes reads and writes in one burst, so a pointer that only moves on writes returns bytes from the wrong address. It stalls both internal streams, which exposes a design that raises ready to the host early or lets a pending write or request change. It also strobes with the select high and after a reselection that had no address phase; a design that does not guard those cases emits stray writes that the scoreboard did not expect.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WR    = 2'd1,
    ST_RDREQ = 2'd2,
    ST_RDOUT = 2'd3
  } hbi_state_e;

  // bit positions inside the synchronized control vector
  localparam int CTL_W  = 4;
  localparam int CS_B   = 3;
  localparam int ALE_B  = 2;
  localparam int RD_B   = 1;
  localparam int WR_B   = 0;
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1011;

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int               WIDTH     = 1,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RESET_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/hbi_edge.sv
module hbi_edge #(
  parameter int               WIDTH     = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RESET_VAL;
    else        prev <= sig;
  end

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise[b] = sig[b] & ~prev[b];
      assign fall[b] = ~sig[b] & prev[b];
    end
  endgenerate
endmodule

// File: rtl/hbi_ptr.sv
module hbi_ptr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_addr;
    else if (inc)  ptr <= ptr + STEP;
  end

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (ptr == ADDR_W'($past(ptr) + STEP)));

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == $past(load_addr)));
endmodule

// File: rtl/host_bus_burst_if.sv
module host_bus_burst_if
  import hbi_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_cs_n,
  input  logic              bus_ale,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  inout  wire  [DATA_W-1:0] bus_data,
  output logic              bus_rdy,
  output logic              reg_wr_valid,
  input  logic              reg_wr_ready,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int BUS_W = ADDR_W + DATA_W;

  // ---------------- synchronizers and edge detection
  logic [CTL_W-1:0] ctl_s, ctl_rise, ctl_fall;
  logic [BUS_W-1:0] bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  hbi_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RESET_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({bus_cs_n, bus_ale, bus_rd_n, bus_wr_n}), .q(ctl_s));

  hbi_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_addr, bus_data}), .q(bus_s));

  assign addr_s = bus_s[BUS_W-1:DATA_W];
  assign data_s = bus_s[DATA_W-1:0];

  hbi_edge #(.WIDTH(CTL_W), .RESET_VAL(CTL_IDLE)) u_ctl_edge (
    .clk(clk), .rst_n(rst_n), .sig(ctl_s), .rise(ctl_rise), .fall(ctl_fall));

  logic cs_act;
  assign cs_act = ~ctl_s[CS_B];

  // ---------------- address pointer
  hbi_state_e        st_q;
  logic              burst_q;
  logic              ptr_load, ptr_inc, wr_push;
  logic [ADDR_W-1:0] ptr;

  assign ptr_load = ctl_fall[ALE_B] & cs_act;
  assign wr_push  = (st_q == ST_WR) & ctl_rise[WR_B] & cs_act;
  assign ptr_inc  = wr_push | ((st_q == ST_RDOUT) & ctl_rise[RD_B] & cs_act);

  hbi_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_addr(addr_s),
    .inc(ptr_inc), .ptr(ptr));

  // ---------------- write stream register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr_valid <= 1'b0;
      reg_wr_addr  <= '0;
      reg_wr_data  <= '0;
    end else if (wr_push) begin
      reg_wr_valid <= 1'b1;
      reg_wr_addr  <= ptr;
      reg_wr_data  <= data_s;
    end else if (reg_wr_ready) begin
      reg_wr_valid <= 1'b0;
    end
  end

  // ---------------- access sequencer
  logic [DATA_W-1:0] rd_byte_q;
  logic              wr_slot_free;
  assign wr_slot_free = ~reg_wr_valid | reg_wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      burst_q   <= 1'b0;
      bus_rdy   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_addr   <= '0;
      rd_byte_q <= '0;
    end else begin
      if (ptr_load)
        burst_q <= 1'b1;
      else if (ctl_rise[CS_B] | ctl_fall[CS_B] | ctl_rise[ALE_B])
        burst_q <= 1'b0;

      if (rd_valid && rd_ready) rd_valid <= 1'b0;

      if (!cs_act) begin
        st_q    <= ST_IDLE;
        bus_rdy <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            bus_rdy <= 1'b0;
            if (burst_q && ctl_fall[WR_B]) begin
              st_q <= ST_WR;
            end else if (burst_q && ctl_fall[RD_B] && !rd_valid) begin
              st_q     <= ST_RDREQ;
              rd_valid <= 1'b1;
              rd_addr  <= ptr;
            end
          end
          ST_WR: begin
            if (ctl_rise[WR_B]) begin
              st_q    <= ST_IDLE;
              bus_rdy <= 1'b0;
            end else begin
              bus_rdy <= wr_slot_free;
            end
          end
          ST_RDREQ: begin
            if (rd_valid && rd_ready) begin
              rd_byte_q <= rd_data;
              st_q      <= ST_RDOUT;
              bus_rdy   <= 1'b1;
            end
          end
          ST_RDOUT: begin
            if (ctl_rise[RD_B]) begin
              st_q    <= ST_IDLE;
              bus_rdy <= 1'b0;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // ---------------- host data drive, from the raw pins
  logic drive_en;
  assign drive_en = ~bus_cs_n & ~bus_rd_n;
  assign bus_data = drive_en ? rd_byte_q : {DATA_W{1'bz}};

  // ---------------- assertions
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_valid && !reg_wr_ready) |=>
      (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data)));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R6
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WR && ctl_rise[WR_B]) |=> !bus_rdy);

  // R9
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s[CS_B] |=> (!$rose(reg_wr_valid) && !$rose(rd_valid)));

  // R6
  rdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdy) |-> (st_q == ST_WR || st_q == ST_RDOUT));
endmodule

// File: tb/tb_host_bus_burst_if.sv
module tb_host_bus_burst_if;
  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_cs_n, bus_ale, bus_rd_n, bus_wr_n;
  wire  [DW-1:0] bus_data;
  logic          host_oe;
  logic [DW-1:0] host_dout;
  logic          bus_rdy, reg_wr_valid, reg_wr_ready, rd_valid, rd_ready;
  logic [AW-1:0] reg_wr_addr, rd_addr;
  logic [DW-1:0] reg_wr_data, rd_data;

  assign bus_data = host_oe ? host_dout : {DW{1'bz}};

  host_bus_burst_if dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_data(bus_data), .bus_rdy(bus_rdy), .reg_wr_valid(reg_wr_valid),
    .reg_wr_ready(reg_wr_ready), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data));

  int n_chk = 0;
  int n_fail = 0;
  bit wr_stall = 1'b0;
  bit rd_stall = 1'b0;
  bit finished = 1'b0;
  logic [AW+DW-1:0] exp_q[$];
  logic [DW-1:0] model [0:2047];
  logic [DW-1:0] expm  [0:2047];
  logic [AW-1:0] ptr_m;

  function automatic logic [DW-1:0] seed_byte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[10:8], 5'h15};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_rdy(input logic lvl, input int lim, output bit hit);
    hit = 1'b0;
    for (int i = 0; i < lim; i++) begin
      tick(1);
      if (bus_rdy == lvl) begin
        hit = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      model[i] = seed_byte(i[AW-1:0]);
      expm[i]  = seed_byte(i[AW-1:0]);
    end
  end

  // register-space responder
  initial begin
    reg_wr_ready = 1'b0;
    rd_ready = 1'b0;
    rd_data = '0;
    forever begin
      @(posedge clk);
      #1;
      reg_wr_ready = !wr_stall;
      rd_ready     = rd_valid && !rd_stall;
      rd_data      = model[rd_addr];
    end
  end

  // scoreboard monitor on the write stream
  always @(negedge clk) begin
    if (rst_n && reg_wr_valid && reg_wr_ready) begin
      model[reg_wr_addr] = reg_wr_data;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9/R10 unexpected write", {13'd0, reg_wr_addr, reg_wr_data}, 32'h0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        chk({reg_wr_addr, reg_wr_data} == e, "R2/R3/R11 write stream",
            {13'd0, reg_wr_addr, reg_wr_data}, {13'd0, e});
      end
    end
  end

  task automatic latch(input logic [AW-1:0] a);
    bus_cs_n = 1'b0;
    bus_addr = a;
    bus_ale  = 1'b1;
    tick(4);
    bus_ale = 1'b0;
    tick(4);
    ptr_m = a;
  endtask

  task automatic end_burst;
    bus_cs_n = 1'b1;
    tick(5);
  endtask

  task automatic host_write(input logic [DW-1:0] d, input string req);
    bit hit;
    exp_q.push_back({ptr_m, d});
    expm[ptr_m] = d;
    ptr_m = ptr_m + 1'b1;
    host_dout = d;
    host_oe   = 1'b1;
    bus_wr_n  = 1'b0;
    wait_rdy(1'b1, 40, hit);
    chk(hit, req, {31'd0, bus_rdy}, 32'd1);
    bus_wr_n = 1'b1;
    tick(4);
    host_oe = 1'b0;
    wait_rdy(1'b0, 10, hit);
    chk(hit, "R6 ready release after write", {31'd0, bus_rdy}, 32'd0);
  endtask

  task automatic host_read(input string req);
    bit hit;
    logic [DW-1:0] e;
    e = expm[ptr_m];
    ptr_m = ptr_m + 1'b1;
    bus_rd_n = 1'b0;
    wait_rdy(1'b1, 40, hit);
    chk(hit, "R6 ready on read", {31'd0, bus_rdy}, 32'd1);
    chk(bus_data == e, req, {24'd0, bus_data}, {24'd0, e});
    bus_rd_n = 1'b1;
    wait_rdy(1'b0, 10, hit);
    chk(hit, "R6 ready release after read", {31'd0, bus_rdy}, 32'd0);
  endtask

  task automatic ignored_access(input string req);
    bit seen;
    seen = 1'b0;
    host_dout = 8'hEE;
    host_oe   = 1'b1;
    bus_wr_n  = 1'b0;
    for (int i = 0; i < 15; i++) begin
      tick(1);
      if (bus_rdy) seen = 1'b1;
    end
    bus_wr_n = 1'b1;
    tick(4);
    host_oe  = 1'b0;
    bus_rd_n = 1'b0;
    for (int i = 0; i < 15; i++) begin
      tick(1);
      if (bus_rdy || rd_valid) seen = 1'b1;
    end
    bus_rd_n = 1'b1;
    tick(4);
    chk(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    bit hit;
    rst_n = 1'b0;
    bus_addr = '0;
    bus_cs_n = 1'b1;
    bus_ale = 1'b0;
    bus_rd_n = 1'b1;
    bus_wr_n = 1'b1;
    host_oe = 1'b0;
    host_dout = '0;
    ptr_m = '0;
    tick(5);
    // R1
    chk(!bus_rdy && !reg_wr_valid && !rd_valid, "R1 reset outputs",
        {29'd0, bus_rdy, reg_wr_valid, rd_valid}, 32'd0);
    rst_n = 1'b1;
    tick(3);

    // R9: strobes with select high
    ignored_access("R9 strobes while deselected");

    // R2 / R3 / R11: basic burst
    latch(11'h123);
    host_write(8'hA1, "R2 first write ready");
    host_write(8'hB2, "R3 second write ready");
    host_write(8'hC3, "R3 third write ready");
    host_write(8'h4D, "R11 fourth write ready");
    end_burst();

    // R3: wrap across the top of the space
    latch(11'h7FE);
    host_write(8'h11, "R3 wrap write 0");
    host_write(8'h22, "R3 wrap write 1");
    host_write(8'h33, "R3 wrap write 2");
    end_burst();

    // R4: read burst returns earlier writes then untouched bytes
    latch(11'h123);
    host_read("R4 read 0x123");
    host_read("R4 read 0x124");
    host_read("R4 read 0x125");
    host_read("R4 read 0x126");
    host_read("R4 read 0x127 untouched");
    end_burst();

    // R4 / R3: mixed burst, reads advance the pointer too
    latch(11'h7FF);
    host_read("R4 mixed read 0x7FF");
    host_write(8'h5C, "R3 mixed write 0x000");
    host_read("R4 mixed read 0x001");
    end_burst();

    // R10: reselect without address phase
    bus_cs_n = 1'b0;
    tick(4);
    ignored_access("R10 strobes without new address phase");
    end_burst();

    // R8: read request stall
    latch(11'h050);
    rd_stall = 1'b1;
    bus_rd_n = 1'b0;
    tick(10);
    chk(rd_valid && rd_addr == 11'h050, "R8 request held under stall",
        {20'd0, rd_valid, rd_addr}, {20'd1, 11'h050});
    chk(!bus_rdy, "R8 ready low while request waits", {31'd0, bus_rdy}, 32'd0);
    rd_stall = 1'b0;
    wait_rdy(1'b1, 20, hit);
    chk(hit && bus_data == seed_byte(11'h050), "R8 read data after stall",
        {24'd0, bus_data}, {24'd0, seed_byte(11'h050)});
    bus_rd_n = 1'b1;
    wait_rdy(1'b0, 10, hit);
    end_burst();

    // R7: write stream back-pressure
    latch(11'h200);
    wr_stall = 1'b1;
    host_write(8'h66, "R7 first write with free slot");
    exp_q.push_back({ptr_m, 8'h77});
    expm[ptr_m] = 8'h77;
    ptr_m = ptr_m + 1'b1;
    host_dout = 8'h77;
    host_oe = 1'b1;
    bus_wr_n = 1'b0;
    tick(15);
    chk(!bus_rdy, "R7 ready low while write pending", {31'd0, bus_rdy}, 32'd0);
    chk(reg_wr_valid && reg_wr_addr == 11'h200 && reg_wr_data == 8'h66,
        "R7 pending write held", {12'd0, reg_wr_valid, reg_wr_addr, reg_wr_data},
        {12'd1, 11'h200, 8'h66});
    wr_stall = 1'b0;
    wait_rdy(1'b1, 20, hit);
    chk(hit, "R7 ready after slot frees", {31'd0, bus_rdy}, 32'd1);
    bus_wr_n = 1'b1;
    tick(4);
    host_oe = 1'b0;
    wait_rdy(1'b0, 10, hit);
    end_burst();

    // R5: no drive with select high
    host_dout = 8'h5A;
    host_oe = 1'b1;
    bus_rd_n = 1'b0;
    tick(3);
    chk(bus_data == 8'h5A, "R5 pins released while deselected",
        {24'd0, bus_data}, 32'h5A);
    bus_rd_n = 1'b1;
    host_oe = 1'b0;
    tick(10);

    chk(exp_q.size() == 0, "R2 all expected writes delivered", exp_q.size(), 32'd0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule